// File: doc/BRIEF.md
# Serial Two's-Complement Adder/Subtractor

This block adds or subtracts two signed operands that arrive one bit per clock, lowest bit first. A single full-adder cell handles every bit position of a word. The carry it produces is held in a flip-flop and fed back as the carry into the next bit of the same word.

A strobe on the lowest bit marks the start of each word. On that bit the feedback carry is ignored. The carry in is forced to 0 for addition or to 1 for subtraction, so each word starts clean and back-to-back words need no gap between them. Subtraction inverts every bit of the second operand and uses that forced carry to add the one.

The operation is sampled on the start bit and held internally for the rest of the word. Each sum bit appears in the same cycle as its operand bits. A bit counter marks the top bit, and on that bit a signed-overflow flag is computed from the sign bits.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous active-high reset clears the bit counter, the carry register and the held mode. While `in_valid` is low, `sum_valid`, `msb` and `ovf` are all 0.
- R2: `sum_valid` equals `in_valid` in the same cycle. `sum_bit` is valid combinationally in the cycle its operand bits are presented.
- R3: With `sub`=0 on the start bit, the W sum bits collected from the start bit upward equal (A+B) mod 2^W. The lowest sum bit is always `a_bit` XOR `b_bit`.
- R4: With `sub`=1 on the start bit, the W sum bits equal (A−B) mod 2^W.
- R5: The `sub` input is sampled only on the start bit. Changing it on later bits of the word has no effect on the result.
- R6: The carry out of a word's top bit never reaches the next word. A word that begins with `start` on the cycle right after the previous word's top bit gives the correct result.
- R7: `msb` is 1 exactly on the W-th valid bit counted from the start bit, with the start bit counted as the first.
- R8: For addition, `ovf` is 1 on the top bit exactly when A and B have equal sign bits and the sign of the sum differs from them. `ovf` is 0 on every other bit.
- R9: For subtraction, `ovf` follows the same rule as R8, using the inverted sign bit of B.
- R10: Cycles with `in_valid` low are idle. The counter, carry and mode hold through them, whatever `a_bit`, `b_bit`, `sub` and `start` carry.
- R11: A `start` arriving in the middle of a word abandons that word. The counting and the carry restart from the new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand bits present this cycle |
| start | input | 1 | Marks the lowest bit of a word |
| sub | input | 1 | 1 = subtract, 0 = add; sampled on the start bit |
| a_bit | input | 1 | Bit of operand A |
| b_bit | input | 1 | Bit of operand B |
| sum_bit | output | 1 | Result bit for the current position |
| sum_valid | output | 1 | Result bit is valid |
| msb | output | 1 | Current bit is the word's top bit |
| ovf | output | 1 | Signed overflow, valid on the top bit |

## Verification
Every output is combinational in the cycle that carries its operand bits. A sum bit, `msb` and `ovf` are therefore due zero cycles after the bit is driven. The bench drives inputs just after the rising edge and samples all outputs on the following falling edge of that same cycle. Result bits are gathered into a word and compared with the expected sum and overflow when `msb` shows. Idle cycles are sampled the same way to confirm that no output moves.

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic start,
  input  logic sub,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic sum_valid,
  output logic msb,
  output logic ovf
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic carry_q, mode_q;
  logic [CW-1:0] idx;
  logic mode, b_eff, cin, cout, top;

  assign idx   = start ? '0 : cnt;
  assign mode  = start ? sub : mode_q;
  assign b_eff = b_bit ^ mode;
  assign cin   = start ? mode : carry_q;
  assign {cout, sum_bit} = {1'b0, a_bit} + {1'b0, b_eff} + {1'b0, cin};
  assign top   = (idx == LAST);

  assign sum_valid = in_valid;
  assign msb       = in_valid & top;
  assign ovf       = msb & (a_bit == b_eff) & (sum_bit != a_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      carry_q <= 1'b0;
      mode_q  <= 1'b0;
    end else if (in_valid) begin
      cnt     <= top ? '0 : idx + 1'b1;
      carry_q <= cout;
      mode_q  <= mode;
    end
  end
endmodule

module serial_addsub_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic start,
  input logic a_bit,
  input logic b_bit,
  input logic sum_bit,
  input logic sum_valid,
  input logic msb,
  input logic ovf
);
  int pos;
  always_ff @(posedge clk) begin
    if (rst) pos <= 0;
    else if (in_valid) pos <= start ? 1 : ((pos >= W) ? 1 : pos + 1);
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (!sum_valid && !msb && !ovf));
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    sum_valid == in_valid);
  p_lsb_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && start) |-> (sum_bit == (a_bit ^ b_bit)));
  p_msb_pos_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !start && pos >= 1) |-> (msb == (pos == W - 1)));
  p_ovf_msb_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |-> msb);
endmodule

bind serial_addsub serial_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .start(start),
  .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_bit),
  .sum_valid(sum_valid), .msb(msb), .ovf(ovf)
);

// File: tb/sim_serial_addsub.sv
module sim_serial_addsub;
  localparam int W = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, start = 0, sub = 0, a_bit = 0, b_bit = 0;
  logic sum_bit, sum_valid, msb, ovf;

  always #4 clk = ~clk;

  serial_addsub #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .start(start), .sub(sub),
    .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_bit), .sum_valid(sum_valid),
    .msb(msb), .ovf(ovf)
  );

  typedef struct {
    logic [W-1:0] sum;
    logic         ov;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic op, input int gap, input bit wobble,
                           input string tag);
    exp_t e;
    logic [W-1:0] r;
    r = op ? a - b : a + b;
    e.sum = r;
    e.ov  = op ? ((a[W-1] != b[W-1]) && (r[W-1] != a[W-1]))
               : ((a[W-1] == b[W-1]) && (r[W-1] != a[W-1]));
    e.tag = tag;
    q.push_back(e);
    for (int i = 0; i < W; i++) begin
      @(posedge clk); #1;
      in_valid = 1; start = (i == 0); a_bit = a[i]; b_bit = b[i];
      sub = (i == 0) ? op : (wobble ? ~op : op);
      for (int g = 0; g < gap && i < W - 1; g++) begin
        @(posedge clk); #1;
        in_valid = 0; start = ~start; a_bit = ~a_bit; b_bit = $urandom;
        sub = ~sub;
      end
    end
    @(posedge clk); #1;
    in_valid = 0; start = 0;
  endtask

  task automatic send_partial(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #1;
      in_valid = 1; start = (i == 0); a_bit = 1; b_bit = 1; sub = 0;
    end
  endtask

  int idx = 0;
  logic [W-1:0] acc = '0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (sum_valid != in_valid) begin
        fails++;
        $display("FAIL R2: sum_valid=%0b expected %0b", sum_valid, in_valid);
      end
      if (!in_valid) begin
        checks++;
        if (msb || ovf) begin
          fails++;
          $display("FAIL R10: idle msb/ovf=%0b%0b expected 00", msb, ovf);
        end
      end else begin
        if (start) begin idx = 0; acc = '0; end
        acc[idx] = sum_bit;
        checks++;
        if (msb != (idx == W - 1)) begin
          fails++;
          $display("FAIL R7: msb=%0b at bit %0d expected %0b", msb, idx, idx == W - 1);
        end
        if (idx != W - 1 && ovf) begin
          fails++;
          $display("FAIL R8: ovf=1 at bit %0d expected 0", idx);
        end
        if (idx == W - 1) begin
          exp_t e;
          if (q.size() == 0) begin
            fails++;
            $display("FAIL R3: unexpected word %h expected none", acc);
          end else begin
            e = q.pop_front();
            checks++;
            if (acc !== e.sum || ovf !== e.ov) begin
              fails++;
              $display("FAIL %s: sum=%h ovf=%0b expected sum=%h ovf=%0b",
                       e.tag, acc, ovf, e.sum, e.ov);
            end
          end
        end
        idx++;
      end
    end
  end

  initial begin
    #400_000;
    fails++;
    $display("FAIL watchdog: run did not finish expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 in_valid = 1; start = 1; a_bit = 1; b_bit = 0;
    @(negedge clk);
    checks++;
    if (sum_valid !== 1'b1 || sum_bit !== 1'b1) begin
      fails++;
      $display("FAIL R2: in reset sum_valid/sum_bit=%0b%0b expected 11", sum_valid, sum_bit);
    end
    @(posedge clk); #1 in_valid = 0; start = 0; rst = 0;
    @(negedge clk);
    checks++;
    if (sum_valid || msb || ovf) begin
      fails++;
      $display("FAIL R1: after reset outputs=%0b%0b%0b expected 000", sum_valid, msb, ovf);
    end

    send_word(8'h12, 8'h34, 0, 0, 0, "R3");
    send_word(8'hFF, 8'h01, 0, 0, 0, "R6");
    send_word(8'h00, 8'h00, 0, 0, 0, "R6");
    send_word(8'h50, 8'h30, 1, 0, 0, "R4");
    send_word(8'h30, 8'h50, 1, 0, 0, "R4");
    send_word(8'h00, 8'h01, 1, 0, 0, "R4");
    send_word(8'h70, 8'h20, 0, 0, 0, "R8");
    send_word(8'h80, 8'hFF, 0, 0, 0, "R8");
    send_word(8'hFF, 8'hFE, 0, 0, 0, "R8");
    send_word(8'h80, 8'h01, 1, 0, 0, "R9");
    send_word(8'h7F, 8'hFF, 1, 0, 0, "R9");
    send_word(8'h00, 8'h80, 1, 0, 0, "R9");
    send_word(8'h3C, 8'h55, 1, 0, 1, "R5");
    send_word(8'hA5, 8'h5A, 0, 0, 1, "R5");
    send_word(8'hC3, 8'h77, 1, 2, 0, "R10");
    send_word(8'h7F, 8'h01, 0, 3, 1, "R10");
    send_partial(5);
    send_word(8'h01, 8'h01, 0, 0, 0, "R11");
    send_partial(3);
    send_word(8'h10, 8'h20, 1, 0, 0, "R11");
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      send_word(ra, rb, k[0], k % 3, k[1], k[0] ? "R4" : "R3");
    end
    repeat (2) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7: %0d words not completed expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule